// File: doc/BRIEF.md
# Write-Hit Test Register Bank

This block is a byte-wide register slave that lets host software confirm that its writes reach a device. It has two address windows, a memory window and an I/O window. Each window has its own write strobe. Both windows share one write address/data bus and one read port. A write of a mode number to byte address 0 of either window selects one of six test descriptors. The descriptor is picked by the window that carried the write and by the mode number. Selecting a descriptor starts a test and clears its hit count.

While a test runs, the block counts the writes that land on that descriptor's trigger offset. The data-match and plain modes also require a one-byte write carrying the magic byte. Software then reads the active descriptor back one byte at a time. The descriptor holds a little-endian header with the descriptor index, the access width, the trigger offset, the expected data byte and the 32-bit hit count, followed by an ASCII name.

Top module: `tstbank_top`

## Requirements
- R1: After reset no test is active. While no test is active, a read returns 0x00 at every address.
- R2: A write to address 0 with value m < 3 activates a descriptor and clears its hit count to zero. Writes on the memory strobe select descriptor m; writes on the I/O strobe select descriptor 3 + m. Mode 0 is plain, mode 1 is wildcard and mode 2 is data-match. Header byte 0 reads back the descriptor index.
- R3: A write to address 0 with a value of 3 or more leaves no test active.
- R4: The trigger offset of descriptor i is the window size plus i: 2048 + i for i < 3, and 128 + i for i >= 3. It reads back little-endian at header bytes 4..7.
- R5: In wildcard mode, every write to the trigger offset is counted, whatever its data or size. In the plain and data-match modes, a write is counted only when wrSize is 1 and wrData is 0xFA.
- R6: A write that matches the active trigger offset is counted whichever window strobe carried it. The block ignores I/O writes at addresses of 256 or more, writes to any other address, and writes made while no test is active.
- R7: The hit count increments by one for each counted write, modulo 2^32. It reads back little-endian at header bytes 12..15, with carries across bytes.
- R8: A read of a count byte in the same cycle as a counted write returns the count from before that write.
- R9: The fixed header fields read back as follows: byte 1 reads 0x01 (access width). Byte 8 reads 0xCE for wildcard descriptors and 0xFA for the others. Bytes 2, 3, 9, 10 and 11 read 0x00.
- R10: From byte 16, reads return the descriptor name. The name is the window word ("mmio" or "portio"), a hyphen, then the mode word ("no-eventfd", "wildcard-eventfd" or "datamatch-eventfd"). Any read at address 16 + name length or above returns 0x00.
- R11: Read data appears on rdData the cycle after rdEn is sampled high. rdData is 0x00 in the cycle after rdEn is sampled low.
- R12: When both strobes are high in the same cycle, the write is treated as a memory-window write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memWrEn | input | 1 | Write strobe for the memory window |
| ioWrEn | input | 1 | Write strobe for the I/O window |
| wrAddr | input | 12 | Byte address of the write within its window |
| wrData | input | 8 | Write data byte |
| wrSize | input | 3 | Size of the write access in bytes |
| rdEn | input | 1 | Read request |
| rdAddr | input | 12 | Byte address of the read |
| rdData | output | 8 | Registered read data byte |

## Verification
Writes take effect at the clock edge that samples them, and a read issued in the next cycle already sees the new selection or count. Read data is registered, so each read result is due one cycle after the edge that samples rdEn. The bench changes inputs on the falling edge and samples rdData on the falling edge after the capturing rising edge. For the same-cycle read-and-count case, the bench presents the read and the counted write together and checks the pre-increment byte in that same sampling slot. It then checks the incremented value with a following read.

// File: rtl/tstbank_pkg.sv
package tstbank_pkg;

  localparam int MODES     = 3;
  localparam int WINDOWS   = 2;
  localparam int DESCS     = MODES * WINDOWS;
  localparam int HDR_BYTES = 16;
  localparam int STR_W     = 8 * 17;

  // strobes and selection from control to datapath
  typedef struct packed {
    logic       active;
    logic [2:0] sel;
    logic       clrCnt;
    logic       incCnt;
  } bankStrb_t;

  function automatic logic [1:0] selMode(input logic [2:0] sel);
    logic [2:0] m;
    m = (sel >= 3'd3) ? sel - 3'd3 : sel;
    return m[1:0];
  endfunction

  function automatic logic selIsIo(input logic [2:0] sel);
    return sel >= 3'd3;
  endfunction

  function automatic logic [31:0] trigOffset(input logic [2:0] sel, input int memWin,
                                             input int ioWin);
    int base;
    base = selIsIo(sel) ? ioWin : memWin;
    return 32'(base + int'(sel));
  endfunction

  function automatic int winLen(input logic [2:0] sel);
    return selIsIo(sel) ? 7 : 5;
  endfunction

  function automatic int modeLen(input logic [1:0] m);
    case (m)
      2'd0:    return 10;
      2'd1:    return 16;
      default: return 17;
    endcase
  endfunction

  function automatic int nameLen(input logic [2:0] sel);
    return winLen(sel) + modeLen(selMode(sel));
  endfunction

  // character k of a right-aligned packed string of length len
  function automatic logic [7:0] strAt(input logic [STR_W-1:0] s, input int len, input int k);
    if (k < 0 || k >= len) return 8'h00;
    return s[(len - 1 - k) * 8 +: 8];
  endfunction

  function automatic logic [7:0] nameChar(input logic [2:0] sel, input int k);
    logic [STR_W-1:0] winStr, modeStr;
    int wl;
    wl = winLen(sel);
    winStr = selIsIo(sel) ? STR_W'("portio-") : STR_W'("mmio-");
    case (selMode(sel))
      2'd0:    modeStr = STR_W'("no-eventfd");
      2'd1:    modeStr = STR_W'("wildcard-eventfd");
      default: modeStr = STR_W'("datamatch-eventfd");
    endcase
    if (k < wl) return strAt(winStr, wl, k);
    return strAt(modeStr, modeLen(selMode(sel)), k - wl);
  endfunction

endpackage

// File: rtl/tstbank_ctrl.sv
module tstbank_ctrl
  import tstbank_pkg::*;
#(
  parameter int          MEM_WIN    = 2048,
  parameter int          IO_WIN     = 128,
  parameter int          ADDR_W     = 12,
  parameter int          SIZE_W     = 3,
  parameter logic [7:0]  MATCH_BYTE = 8'hFA
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memWrEn,
  input  logic              ioWrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [SIZE_W-1:0] wrSize,
  output bankStrb_t         strb
);

  localparam int IO_SPAN = 2 * IO_WIN;

  logic       active;
  logic [2:0] sel;
  logic       ioOk, anyWr, wrIsIo, modeWr, modeOk, wildSel, addrHit, dataOk;
  logic [2:0] newSel;

  always_comb begin
    ioOk    = ioWrEn && (32'(wrAddr) < 32'(IO_SPAN));
    anyWr   = memWrEn || ioOk;
    wrIsIo  = !memWrEn;                       // memory strobe wins
    modeWr  = anyWr && (wrAddr == '0);
    modeOk  = wrData < 8'(MODES);
    newSel  = wrIsIo ? (3'(MODES) + wrData[2:0]) : wrData[2:0];
    wildSel = selMode(sel) == 2'd1;
    addrHit = 32'(wrAddr) == trigOffset(sel, MEM_WIN, IO_WIN);
    dataOk  = wildSel || ((wrSize == SIZE_W'(1)) && (wrData == MATCH_BYTE));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      sel    <= '0;
    end else if (modeWr) begin
      active <= modeOk;
      if (modeOk) sel <= newSel;
    end
  end

  always_comb begin
    strb.active = active;
    strb.sel    = sel;
    strb.clrCnt = modeWr && modeOk;
    strb.incCnt = anyWr && !modeWr && active && addrHit && dataOk;
  end

  AST_BAD_MODE_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && wrAddr == '0 && wrData >= 8'd3) |=> !strb.active); // R3

  AST_MEM_MODE_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (memWrEn && wrAddr == '0 && wrData < 8'd3)
      |=> (strb.active && strb.sel == 3'($past(wrData)))); // R2

  AST_IO_MODE_SEL: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && !memWrEn && wrAddr == '0 && wrData < 8'd3)
      |=> (strb.active && strb.sel == 3'($past(wrData)) + 3'd3)); // R2

  AST_IO_OUT_OF_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (ioWrEn && !memWrEn && 32'(wrAddr) >= 32'(IO_SPAN))
      |-> (!strb.incCnt && !strb.clrCnt)); // R6

  AST_MATCH_RULE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCnt && selMode(strb.sel) != 2'd1)
      |-> (wrSize == SIZE_W'(1) && wrData == MATCH_BYTE)); // R5

endmodule

// File: rtl/tstbank_dp.sv
module tstbank_dp
  import tstbank_pkg::*;
#(
  parameter int         MEM_WIN    = 2048,
  parameter int         IO_WIN     = 128,
  parameter int         ADDR_W     = 12,
  parameter int         CNT_W      = 32,
  parameter logic [7:0] MATCH_BYTE = 8'hFA,
  parameter logic [7:0] WILD_BYTE  = 8'hCE
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrb_t         strb,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);

  localparam int WORD_BYTES = 4;

  logic [CNT_W-1:0] cnt;
  logic [31:0]      cntWord, trigWord;
  logic [7:0]       cntBytes  [WORD_BYTES];
  logic [7:0]       trigBytes [WORD_BYTES];
  logic [7:0]       byteVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.clrCnt) cnt <= '0;
    else if (strb.incCnt) cnt <= cnt + CNT_W'(1);
  end

  assign cntWord  = 32'(cnt);
  assign trigWord = trigOffset(strb.sel, MEM_WIN, IO_WIN);

  for (genvar b = 0; b < WORD_BYTES; b++) begin : gSlice
    assign cntBytes[b]  = cntWord[8*b +: 8];
    assign trigBytes[b] = trigWord[8*b +: 8];
  end

  always_comb begin
    int idx;
    idx     = int'(rdAddr);
    byteVal = 8'h00;
    if (strb.active && idx < HDR_BYTES + nameLen(strb.sel)) begin
      if (idx >= HDR_BYTES) begin
        byteVal = nameChar(strb.sel, idx - HDR_BYTES);
      end else begin
        case (idx)
          0:              byteVal = 8'(strb.sel);
          1:              byteVal = 8'd1;
          4, 5, 6, 7:     byteVal = trigBytes[rdAddr[1:0]];
          8:              byteVal = (selMode(strb.sel) == 2'd1) ? WILD_BYTE : MATCH_BYTE;
          12, 13, 14, 15: byteVal = cntBytes[rdAddr[1:0]];
          default:        byteVal = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= 8'h00;
    else       rdData <= rdEn ? byteVal : 8'h00;
  end

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrCnt |=> (cnt == '0)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incCnt && !strb.clrCnt) |=> (cnt == $past(cnt) + CNT_W'(1))); // R7

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.incCnt && !strb.clrCnt) |=> $stable(cnt)); // R6

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.incCnt && strb.clrCnt)); // R2

  AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn || !strb.active) |=> (rdData == 8'h00)); // R1

endmodule

// File: rtl/tstbank_top.sv
module tstbank_top
  import tstbank_pkg::*;
#(
  parameter int         MEM_WIN    = 2048,
  parameter int         IO_WIN     = 128,
  parameter int         CNT_W      = 32,
  parameter int         SIZE_W     = 3,
  parameter logic [7:0] MATCH_BYTE = 8'hFA,
  parameter logic [7:0] WILD_BYTE  = 8'hCE,
  parameter int         ADDR_W     = $clog2(2 * MEM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              memWrEn,
  input  logic              ioWrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData
);

  bankStrb_t strb;

  tstbank_ctrl #(
    .MEM_WIN(MEM_WIN), .IO_WIN(IO_WIN), .ADDR_W(ADDR_W),
    .SIZE_W(SIZE_W), .MATCH_BYTE(MATCH_BYTE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .memWrEn(memWrEn), .ioWrEn(ioWrEn),
    .wrAddr(wrAddr), .wrData(wrData), .wrSize(wrSize), .strb(strb)
  );

  tstbank_dp #(
    .MEM_WIN(MEM_WIN), .IO_WIN(IO_WIN), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .MATCH_BYTE(MATCH_BYTE), .WILD_BYTE(WILD_BYTE)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: tb/tstbank_top_test.sv
module tstbank_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        memWrEn = 1'b0, ioWrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] wrAddr = '0, rdAddr = '0;
  logic [7:0]  wrData = '0;
  logic [2:0]  wrSize = 3'd1;
  logic [7:0]  rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tstbank_top uut (
    .clk(clk), .rstN(rstN), .memWrEn(memWrEn), .ioWrEn(ioWrEn),
    .wrAddr(wrAddr), .wrData(wrData), .wrSize(wrSize),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  string nameTab [6] = '{"mmio-no-eventfd", "mmio-wildcard-eventfd", "mmio-datamatch-eventfd",
                         "portio-no-eventfd", "portio-wildcard-eventfd", "portio-datamatch-eventfd"};

  // op: 0 memory write, 1 I/O write, 2 read and compare
  typedef struct packed {
    logic [1:0]  op;
    logic [11:0] addr;
    logic [7:0]  data;
    logic [2:0]  size;
    logic [7:0]  exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 29;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 12'h000, 8'h00, 3'd1, 8'h00, 4'd2},   // start mem plain
    '{2'd0, 12'h800, 8'hFA, 3'd1, 8'h00, 4'd5},   // counted
    '{2'd0, 12'h800, 8'h55, 3'd1, 8'h00, 4'd5},   // wrong data
    '{2'd0, 12'h800, 8'hFA, 3'd2, 8'h00, 4'd5},   // wrong size
    '{2'd0, 12'h801, 8'hFA, 3'd1, 8'h00, 4'd6},   // other address
    '{2'd1, 12'h800, 8'hFA, 3'd1, 8'h00, 4'd6},   // I/O outside span
    '{2'd2, 12'd12,  8'h00, 3'd1, 8'h01, 4'd5},
    '{2'd2, 12'd0,   8'h00, 3'd1, 8'h00, 4'd2},
    '{2'd0, 12'h000, 8'h01, 3'd1, 8'h00, 4'd2},   // start mem wildcard
    '{2'd0, 12'h801, 8'h12, 3'd4, 8'h00, 4'd5},
    '{2'd0, 12'h801, 8'h00, 3'd1, 8'h00, 4'd5},
    '{2'd2, 12'd12,  8'h00, 3'd1, 8'h02, 4'd5},
    '{2'd2, 12'd8,   8'h00, 3'd1, 8'hCE, 4'd9},
    '{2'd1, 12'h000, 8'h02, 3'd1, 8'h00, 4'd2},   // start io datamatch
    '{2'd1, 12'h085, 8'hFA, 3'd1, 8'h00, 4'd5},
    '{2'd0, 12'h085, 8'hFA, 3'd1, 8'h00, 4'd6},   // via memory strobe
    '{2'd1, 12'h085, 8'hFB, 3'd1, 8'h00, 4'd5},
    '{2'd2, 12'd12,  8'h00, 3'd1, 8'h02, 4'd6},
    '{2'd2, 12'd0,   8'h00, 3'd1, 8'h05, 4'd2},
    '{2'd2, 12'd4,   8'h00, 3'd1, 8'h85, 4'd4},
    '{2'd2, 12'd5,   8'h00, 3'd1, 8'h00, 4'd4},
    '{2'd1, 12'h000, 8'h03, 3'd1, 8'h00, 4'd3},   // invalid mode
    '{2'd2, 12'd1,   8'h00, 3'd1, 8'h00, 4'd3},
    '{2'd1, 12'h085, 8'hFA, 3'd1, 8'h00, 4'd6},   // idle write
    '{2'd1, 12'h000, 8'h01, 3'd1, 8'h00, 4'd2},   // start io wildcard
    '{2'd2, 12'd12,  8'h00, 3'd1, 8'h00, 4'd2},
    '{2'd1, 12'h084, 8'h33, 3'd1, 8'h00, 4'd5},
    '{2'd2, 12'd12,  8'h00, 3'd1, 8'h01, 4'd5},
    '{2'd2, 12'd8,   8'h00, 3'd1, 8'hCE, 4'd9}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input bit io, input logic [11:0] a, input logic [7:0] d,
                    input logic [2:0] sz);
    memWrEn = !io; ioWrEn = io; wrAddr = a; wrData = d; wrSize = sz;
    @(posedge clk); @(negedge clk);
    memWrEn = 1'b0; ioWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    rdEn = 1'b1; rdAddr = a;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0;
    v = rdData;
  endtask

  function automatic logic [7:0] refByte(input int idx, input int a, input int unsigned cnt);
    int len, off;
    len = nameTab[idx].len();
    off = ((idx >= 3) ? 128 : 2048) + idx;
    if (a >= 16 + len) return 8'h00;
    if (a >= 16) return nameTab[idx][a - 16];
    case (a)
      0:              return 8'(idx);
      1:              return 8'h01;
      4, 5, 6, 7:     return 8'(off >> (8 * (a - 4)));
      8:              return (idx % 3 == 1) ? 8'hCE : 8'hFA;
      12, 13, 14, 15: return 8'(cnt >> (8 * (a - 12)));
      default:        return 8'h00;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: idle after reset
    rd(12'd0, v);  check("R1 reset byte0", v, 8'h00);
    rd(12'd1, v);  check("R1 reset width", v, 8'h00);
    rd(12'd16, v); check("R1 reset name", v, 8'h00);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].op == 2'd2) begin
        rd(VECS[i].addr, v);
        check($sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
      end else begin
        wr(VECS[i].op == 2'd1, VECS[i].addr, VECS[i].data, VECS[i].size);
      end
    end

    // R4 R9 R10: full descriptor sweep with idx+1 hits each
    for (int d = 0; d < 6; d++) begin
      int off;
      off = ((d >= 3) ? 128 : 2048) + d;
      wr(d >= 3, 12'd0, 8'(d % 3), 3'd1);
      for (int h = 0; h <= d; h++) wr(1'b0, 12'(off), 8'hFA, 3'd1);
      for (int a = 0; a < 16 + nameTab[d].len() + 3; a++) begin
        rd(12'(a), v);
        check($sformatf("R10 R4 R9 desc %0d byte %0d", d, a), v,
              refByte(d, a, 32'(d + 1)));
      end
    end

    // R7: carry across count bytes
    wr(1'b0, 12'd0, 8'd1, 3'd1);
    for (int h = 0; h < 259; h++) wr(1'b0, 12'h801, 8'(h), 3'd1);
    rd(12'd12, v); check("R7 count byte0", v, 8'h03);
    rd(12'd13, v); check("R7 count byte1", v, 8'h01);
    rd(12'd14, v); check("R7 count byte2", v, 8'h00);

    // R8: read and counted write in the same cycle
    wr(1'b0, 12'd0, 8'd2, 3'd1);
    for (int h = 0; h < 5; h++) wr(1'b0, 12'h802, 8'hFA, 3'd1);
    rdEn = 1'b1; rdAddr = 12'd12;
    memWrEn = 1'b1; wrAddr = 12'h802; wrData = 8'hFA; wrSize = 3'd1;
    @(posedge clk); @(negedge clk);
    rdEn = 1'b0; memWrEn = 1'b0;
    check("R8 pre-increment", rdData, 8'h05);
    rd(12'd12, v); check("R8 after increment", v, 8'h06);

    // R11: rdData clears when no read is sampled
    rd(12'd1, v); check("R11 read data", v, 8'h01);
    @(posedge clk); @(negedge clk);
    check("R11 idle read data", rdData, 8'h00);

    // R12: both strobes, memory wins
    memWrEn = 1'b1; ioWrEn = 1'b1; wrAddr = 12'd0; wrData = 8'd1; wrSize = 3'd1;
    @(posedge clk); @(negedge clk);
    memWrEn = 1'b0; ioWrEn = 1'b0;
    rd(12'd0, v); check("R12 selected index", v, 8'h01);
    rd(12'd5, v); check("R12 trigger byte1", v, 8'h08);

    // R1: reset while a test is active
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    rd(12'd1, v);  check("R1 after reset width", v, 8'h00);
    rd(12'd8, v);  check("R1 after reset data", v, 8'h00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule